// File: doc/BRIEF.md
# Bus Sizing and Byte-Strobe Generator

This block sits between a CPU load/store port and the external bus cycle sequencer. It accepts one byte or word access at a time, on a 24-bit byte address, and turns it into one or two external bus cycles. For each cycle it decides which data lanes carry the bytes and which strobes (read, high-lane write, low-lane write) are raised. The external data bus is 16 bits wide or 8 bits wide, chosen by a mode input.

In narrow mode all traffic uses the upper lane (bits 15:8). A word access is broken into two byte cycles: the even byte goes first, then the odd byte. In wide mode the write strobes follow the address parity, and a word moves in a single cycle. Read data is collected across the cycles and returned to the CPU as one value. A single done pulse marks the end of the access.

Strobes leave this block as active-high request fields. The sequencer drives the real pins with the polarity and timing it needs.

Top module: `bus_sizer`

## Requirements
- R1: During and after synchronous reset, `cpu_done_o`, `cpu_err_o`, `seq_req_o` and all three strobes are low.
- R2: With `bus16_i` = 0, every bus cycle uses only the upper lane: `seq_lwr_o` stays low and `seq_wdata_o[7:0]` is 0. A byte write raises `seq_hwr_o` with the CPU byte (`cpu_wdata_i[7:0]`) on `seq_wdata_o[15:8]`.
- R3: With `bus16_i` = 1, a byte write to an even address raises only `seq_hwr_o`, with the byte on `seq_wdata_o[15:8]`. A byte write to an odd address raises only `seq_lwr_o`, with the byte on `seq_wdata_o[7:0]`.
- R4: With `bus16_i` = 1, a word write is one bus cycle. Both write strobes are raised together and `seq_wdata_o` equals `cpu_wdata_i`.
- R5: Reads raise only `seq_rd_o`, at both widths. Writes never raise `seq_rd_o`. While a cycle is requested, exactly one of read or write is signalled.
- R6: With `bus16_i` = 0, a word access is two bus cycles, the first at address A and the second at A+1. A word write puts `cpu_wdata_i[15:8]` on the upper lane first, then `cpu_wdata_i[7:0]`. A word read returns the first upper-lane byte in bits 15:8 and the second in bits 7:0.
- R7: With `bus16_i` = 1, a byte read at an even address returns `seq_rdata_i[15:8]`, and one at an odd address returns `seq_rdata_i[7:0]`. In both cases the byte is placed in `cpu_rdata_o[7:0]` with bits 15:8 zero. A word read returns `seq_rdata_i` unchanged. A narrow byte read returns `seq_rdata_i[15:8]` in bits 7:0.
- R8: A word access whose address bit 0 is 1 produces no bus cycle. In the cycle after it is accepted, `cpu_done_o` and `cpu_err_o` both pulse high.
- R9: `seq_req_o` stays high, with address and strobes unchanged, until `seq_ack_i`. `cpu_done_o` pulses for one cycle, the cycle after the ack of the final bus cycle, and never after an earlier one.
- R10: A `cpu_req_i` raised while an access is in progress is ignored. The running access keeps its address and data, and no extra cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus16_i | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| cpu_req_i | input | 1 | Access request; taken when idle |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_word_i | input | 1 | 1 = word access, 0 = byte access |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_wdata_i | input | 16 | Write data; a byte uses bits 7:0 |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_err_o | output | 1 | Misaligned word, valid with done |
| cpu_rdata_o | output | 16 | Assembled read data, valid with done |
| seq_req_o | output | 1 | Bus cycle requested |
| seq_addr_o | output | ADDR_W | Address of the current bus cycle |
| seq_rd_o | output | 1 | Read strobe request |
| seq_hwr_o | output | 1 | Upper-lane write strobe request |
| seq_lwr_o | output | 1 | Lower-lane write strobe request |
| seq_wdata_o | output | 16 | Lane-steered write data |
| seq_ack_i | input | 1 | Current bus cycle finished |
| seq_rdata_i | input | 16 | Bus read data, valid with ack |

## Verification
The bench covers every mode, direction, size and address parity. It targets these mistakes:
- Swapping the parity-to-strobe mapping would put odd bytes on the upper lane in wide mode.
- Getting the byte order of a narrow word wrong would return the two bytes swapped, or place the second cycle at A instead of A+1.
- Failing to reject a misaligned word would start a bus cycle where the error pulse belongs.
- Raising done early would show a pulse before the second split cycle.
- Using the live CPU inputs instead of latched ones would let a request poked mid-access change the address or start a stray cycle.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = BUS_W / 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } bsz_state_e;

    typedef struct packed {
        logic bus16;
        logic wr;
        logic word;
    } bsz_cmd_t;

    typedef struct packed {
        logic             rd;
        logic             hwr;
        logic             lwr;
        logic [BUS_W-1:0] data;
    } bsz_lane_t;

    function automatic logic needs_split(input bsz_cmd_t c);
        return c.word && !c.bus16;
    endfunction

    function automatic logic misaligned(input logic word, input logic a0);
        return word && a0;
    endfunction

endpackage

// File: rtl/bsz_lane.sv
module bsz_lane
    import bsz_pkg::*;
(
    input  bsz_cmd_t         cmd,
    input  logic             a0,
    input  logic             second,
    input  logic [BUS_W-1:0] wdata,
    output bsz_lane_t        lane
);
    localparam int HI = BUS_W - 1;

    always_comb begin
        lane = '0;
        if (!cmd.wr) begin
            lane.rd = 1'b1;
        end else if (!cmd.bus16) begin
            lane.hwr = 1'b1;
            if (cmd.word && !second)
                lane.data[HI:BYTE_W] = wdata[HI:BYTE_W];
            else
                lane.data[HI:BYTE_W] = wdata[BYTE_W-1:0];
        end else if (cmd.word) begin
            lane.hwr  = 1'b1;
            lane.lwr  = 1'b1;
            lane.data = wdata;
        end else if (a0) begin
            lane.lwr               = 1'b1;
            lane.data[BYTE_W-1:0]  = wdata[BYTE_W-1:0];
        end else begin
            lane.hwr               = 1'b1;
            lane.data[HI:BYTE_W]   = wdata[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/bsz_merge.sv
module bsz_merge
    import bsz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bsz_cmd_t         cmd,
    input  logic             a0,
    input  logic             take_first,
    input  logic             take_final,
    input  logic [BUS_W-1:0] bus_data,
    output logic [BUS_W-1:0] rdata
);
    localparam int HI = BUS_W - 1;

    logic [BYTE_W-1:0] hi_q;
    logic [BUS_W-1:0]  joined;

    always_comb begin
        joined = '0;
        if (needs_split(cmd))
            joined = {hi_q, bus_data[HI:BYTE_W]};
        else if (cmd.word)
            joined = bus_data;
        else if (cmd.bus16 && a0)
            joined[BYTE_W-1:0] = bus_data[BYTE_W-1:0];
        else
            joined[BYTE_W-1:0] = bus_data[HI:BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            rdata <= '0;
        end else begin
            if (take_first && !cmd.wr)
                hi_q <= bus_data[HI:BYTE_W];
            if (take_final && !cmd.wr)
                rdata <= joined;
        end
    end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus16_i,
    input  logic              cpu_req_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_word_i,
    input  logic              cpu_wr_i,
    input  logic [15:0]       cpu_wdata_i,
    output logic              cpu_done_o,
    output logic              cpu_err_o,
    output logic [15:0]       cpu_rdata_o,
    output logic              seq_req_o,
    output logic [ADDR_W-1:0] seq_addr_o,
    output logic              seq_rd_o,
    output logic              seq_hwr_o,
    output logic              seq_lwr_o,
    output logic [15:0]       seq_wdata_o,
    input  logic              seq_ack_i,
    input  logic [15:0]       seq_rdata_i
);
    bsz_state_e        st;
    bsz_cmd_t          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  wdata_q;
    logic              done_q, err_q;
    logic              busy, second, split, last_ack, first_ack;
    bsz_lane_t         lane;

    assign busy      = (st != ST_IDLE);
    assign second    = (st == ST_SECOND);
    assign split     = needs_split(cmd_q);
    assign first_ack = (st == ST_FIRST) && seq_ack_i && split;
    assign last_ack  = seq_ack_i && (second || (st == ST_FIRST && !split));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cmd_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st)
                ST_IDLE: if (cpu_req_i) begin
                    if (misaligned(cpu_word_i, cpu_addr_i[0])) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        cmd_q   <= '{bus16: bus16_i, wr: cpu_wr_i, word: cpu_word_i};
                        addr_q  <= cpu_addr_i;
                        wdata_q <= cpu_wdata_i;
                        st      <= ST_FIRST;
                    end
                end
                ST_FIRST: if (seq_ack_i) begin
                    if (split) begin
                        st <= ST_SECOND;
                    end else begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                ST_SECOND: if (seq_ack_i) begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    bsz_lane u_lane (
        .cmd    (cmd_q),
        .a0     (addr_q[0]),
        .second (second),
        .wdata  (wdata_q),
        .lane   (lane)
    );

    bsz_merge u_merge (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd_q),
        .a0         (addr_q[0]),
        .take_first (first_ack),
        .take_final (last_ack),
        .bus_data   (seq_rdata_i),
        .rdata      (cpu_rdata_o)
    );

    assign seq_req_o   = busy;
    assign seq_addr_o  = addr_q + ADDR_W'(second);
    assign seq_rd_o    = busy && lane.rd;
    assign seq_hwr_o   = busy && lane.hwr;
    assign seq_lwr_o   = busy && lane.lwr;
    assign seq_wdata_o = busy ? lane.data : '0;
    assign cpu_done_o  = done_q;
    assign cpu_err_o   = err_q;
endmodule

// File: rtl/bsz_check.sv
module bsz_check #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              bus16_i,
    input logic              cpu_done_o,
    input logic              cpu_err_o,
    input logic              seq_req_o,
    input logic [ADDR_W-1:0] seq_addr_o,
    input logic              seq_rd_o,
    input logic              seq_hwr_o,
    input logic              seq_lwr_o,
    input logic [15:0]       seq_wdata_o,
    input logic              seq_ack_i
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !seq_req_o |-> !(seq_rd_o || seq_hwr_o || seq_lwr_o)) else $error("idle strobe"); // R1

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (seq_req_o && !bus16_i) |-> (!seq_lwr_o && seq_wdata_o[7:0] == 8'h00)) else $error("narrow lane"); // R2

    AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (rst)
        (seq_req_o && seq_hwr_o && seq_lwr_o) |-> (bus16_i && !seq_addr_o[0])) else $error("pair odd"); // R4

    AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
        seq_req_o |-> (seq_rd_o != (seq_hwr_o || seq_lwr_o))) else $error("direction"); // R5

    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cpu_err_o |-> (cpu_done_o && !seq_req_o)) else $error("err cycle"); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (seq_req_o && !seq_ack_i) |=> (seq_req_o && $stable(seq_addr_o))) else $error("req drop"); // R9

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (cpu_done_o && !cpu_err_o) |-> $past(seq_ack_i && seq_req_o)) else $error("early done"); // R9
endmodule

bind bus_sizer bsz_check #(.ADDR_W(ADDR_W)) u_bsz_check (
    .clk         (clk),
    .rst         (rst),
    .bus16_i     (bus16_i),
    .cpu_done_o  (cpu_done_o),
    .cpu_err_o   (cpu_err_o),
    .seq_req_o   (seq_req_o),
    .seq_addr_o  (seq_addr_o),
    .seq_rd_o    (seq_rd_o),
    .seq_hwr_o   (seq_hwr_o),
    .seq_lwr_o   (seq_lwr_o),
    .seq_wdata_o (seq_wdata_o),
    .seq_ack_i   (seq_ack_i)
);

// File: tb/test_bus_sizer.sv
module test_bus_sizer;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus16_i = 1'b0, cpu_req_i = 1'b0, cpu_word_i = 1'b0, cpu_wr_i = 1'b0;
    logic [AW-1:0] cpu_addr_i = '0;
    logic [15:0]   cpu_wdata_i = '0, seq_rdata_i = '0;
    logic          seq_ack_i = 1'b0;
    logic          cpu_done_o, cpu_err_o, seq_req_o, seq_rd_o, seq_hwr_o, seq_lwr_o;
    logic [15:0]   cpu_rdata_o, seq_wdata_o;
    logic [AW-1:0] seq_addr_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bus_sizer #(.ADDR_W(AW)) i_bus_sizer (.*);

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic access(input logic b16, input logic wr, input logic word,
                          input logic [AW-1:0] a, input int waits, input logic poke);
        logic [15:0]   wd;
        logic [15:0]   p [2];
        logic [15:0]   exp_rd;
        logic [15:0]   exp_wd;
        logic [AW-1:0] exp_a;
        logic          eh, el;
        int            n;
        wd   = a[15:0] ^ 16'h5A3C;
        p[0] = 16'hC3A5 ^ {a[7:0], 8'h11};
        p[1] = 16'h7E81 ^ {8'h22, a[7:0]};
        n    = (word && !b16) ? 2 : 1;
        @(negedge clk);
        bus16_i = b16; cpu_wr_i = wr; cpu_word_i = word; cpu_addr_i = a;
        cpu_wdata_i = wd; cpu_req_i = 1'b1;
        @(negedge clk);
        cpu_req_i = 1'b0;
        if (word && a[0]) begin
            chk(cpu_done_o && cpu_err_o && !seq_req_o, "R8 reject",
                {29'd0, cpu_done_o, cpu_err_o, seq_req_o}, 32'h6);
            @(negedge clk);
            chk(!cpu_done_o && !seq_req_o, "R8 no cycle", {30'd0, cpu_done_o, seq_req_o}, 0);
            return;
        end
        for (int k = 0; k < n; k++) begin
            exp_a = a + AW'(k);
            if (!wr) begin
                eh = 1'b0; el = 1'b0; exp_wd = 16'h0;
            end else if (!b16) begin
                eh = 1'b1; el = 1'b0;
                exp_wd = {(word && k == 0) ? wd[15:8] : wd[7:0], 8'h00};
            end else if (word) begin
                eh = 1'b1; el = 1'b1; exp_wd = wd;
            end else begin
                eh = !a[0]; el = a[0];
                exp_wd = a[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00};
            end
            chk(seq_req_o && !cpu_done_o, "R9 cycle requested", {30'd0, seq_req_o, cpu_done_o}, 32'h2);
            chk(seq_addr_o == exp_a, word && !b16 ? "R6 split address" : "R9 address", 32'(seq_addr_o), 32'(exp_a));
            chk(seq_rd_o == !wr, "R5 read strobe", 32'(seq_rd_o), 32'(!wr));
            chk({seq_hwr_o, seq_lwr_o} == {eh, el},
                !b16 ? "R2 narrow strobes" : (word ? "R4 word strobes" : "R3 parity strobes"),
                {30'd0, seq_hwr_o, seq_lwr_o}, {30'd0, eh, el});
            if (wr)
                chk(seq_wdata_o == exp_wd,
                    !b16 ? (word ? "R6 split data" : "R2 narrow data") : (word ? "R4 word data" : "R3 lane data"),
                    32'(seq_wdata_o), 32'(exp_wd));
            for (int w = 0; w < waits; w++) begin
                if (poke && k == 0 && w == 0) begin
                    cpu_req_i = 1'b1; cpu_addr_i = a ^ 24'h0F0F0E; cpu_wdata_i = ~wd;
                end
                @(negedge clk);
                cpu_req_i = 1'b0;
                chk(seq_req_o && !cpu_done_o && seq_addr_o == exp_a, poke ? "R10 busy request ignored" : "R9 held",
                    32'(seq_addr_o), 32'(exp_a));
                if (poke && wr)
                    chk(seq_wdata_o == exp_wd, "R10 data kept", 32'(seq_wdata_o), 32'(exp_wd));
            end
            seq_ack_i = 1'b1; seq_rdata_i = p[k];
            @(negedge clk);
            seq_ack_i = 1'b0; seq_rdata_i = 16'h0;
        end
        if (!b16)
            exp_rd = word ? {p[0][15:8], p[1][15:8]} : {8'h00, p[0][15:8]};
        else if (word)
            exp_rd = p[0];
        else
            exp_rd = a[0] ? {8'h00, p[0][7:0]} : {8'h00, p[0][15:8]};
        chk(cpu_done_o && !cpu_err_o && !seq_req_o, "R9 done after final ack",
            {29'd0, cpu_done_o, cpu_err_o, seq_req_o}, 32'h4);
        if (!wr)
            chk(cpu_rdata_o == exp_rd, word && !b16 ? "R6 assembled read" : "R7 read lane",
                32'(cpu_rdata_o), 32'(exp_rd));
        @(negedge clk);
        chk(!cpu_done_o && !seq_req_o, "R10 no stray cycle", {30'd0, cpu_done_o, seq_req_o}, 0);
    endtask

    initial begin
        logic [AW-1:0] addrs [6];
        addrs[0] = 24'h000000; addrs[1] = 24'h000001; addrs[2] = 24'hABCDE2;
        addrs[3] = 24'h12345B; addrs[4] = 24'hFFFFFE; addrs[5] = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        chk(!cpu_done_o && !cpu_err_o && !seq_req_o && !seq_rd_o && !seq_hwr_o && !seq_lwr_o,
            "R1 reset state", {26'd0, cpu_done_o, cpu_err_o, seq_req_o, seq_rd_o, seq_hwr_o, seq_lwr_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_done_o && !seq_req_o, "R1 after reset", {30'd0, cpu_done_o, seq_req_o}, 0);
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 2; s++)
                    for (int i = 0; i < 6; i++)
                        for (int w = 0; w < 3; w++)
                            access(m[0], d[0], s[0], addrs[i], w, w == 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule